// File: doc/BRIEF.md
# CPU Reset Sequencer with Start-Address Fetch

This block governs how a small 16-bit processor core enters and leaves reset. An active-low reset pin is brought into the system clock domain through a short flop chain. It is then qualified: a low level counts as a reset request only once it has been seen on enough consecutive system-clock edges. Shorter dips are discarded. While the request is held, the block drives a set of initial values toward the core's status register, system stack pointer and clock gear. It also overrides three pin controls: the watchdog output, the address-latch-enable output enable and the clock output.

When the pin returns high, the block reads the start address from memory over a plain byte-wide read port. The port has one cycle of read latency, and the block issues one read per cycle to three ascending byte addresses. The bytes are assembled lowest-order first into a 24-bit program counter value. A single-cycle start pulse then releases the core. A new reset during the fetch abandons it and returns the block to the held state. The core's other registers and RAM are not touched: the block presents only the program counter, status and stack-pointer values, and their load enables.

Top module: `cpu_boot_sequencer`

## Requirements
- R1: A reset request is accepted only after the synchronized pin has been low on LOW_CYCLES (default 10) consecutive clock edges. The pin passes through SYNC_STAGES (default 2) flops first. A shorter low pulse causes no held state, no memory read and no start pulse.
- R2: After release, the block issues exactly three reads, one per cycle, to addresses VEC_BASE (default 0x008000), VEC_BASE+1 and VEC_BASE+2 in that order. The read data is taken on mem_rdata one cycle after each mem_rd.
- R3: pc_value equals {byte at VEC_BASE+2, byte at VEC_BASE+1, byte at VEC_BASE}. cpu_start is high for exactly one cycle, after the last byte has been captured, and pc_value holds afterwards.
- R4: While held in reset (reset_active=1), init_en=1, init_imask=3'b111, init_max=1, init_bank=3'b000 and init_xsp=24'h000100. Outside the held state, init_en=0 and these outputs read zero.
- R5: While held, gear_sel=3'd4, which selects the divide-by-16 gear, so the system clock is the input clock divided by 32. Outside the held state, gear_sel reads zero.
- R6: While held, wdt_out=0, ale_oe=0 (address-latch-enable tristated) and clk_out=1. Otherwise wdt_out follows wdt_core, ale_oe=1 and clk_out follows sysclk_core.
- R7: A synchronized low pin seen during the fetch aborts it at once, without the R1 qualification. The block enters the held state with no start pulse, and fetches again from VEC_BASE after the next release.
- R8: While por_n is low, the block is in the held state with cpu_hold=1 and cpu_start=0. cpu_hold stays 1 until the cycle after the start pulse and is 0 during normal running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear of the sequencer, active low |
| rst_pin_n | input | 1 | Raw external reset pin, active low, asynchronous |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 24 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| pc_value | output | 24 | Assembled start address |
| cpu_start | output | 1 | One-cycle pulse that starts the core at pc_value |
| cpu_hold | output | 1 | Core held (reset or fetch in progress) |
| reset_active | output | 1 | Accepted reset is being held |
| init_en | output | 1 | Load enable for the initial register values |
| init_imask | output | 3 | Initial interrupt mask level |
| init_max | output | 1 | Initial maximum-mode bit |
| init_bank | output | 3 | Initial register bank pointer |
| init_xsp | output | 24 | Initial system stack pointer |
| gear_sel | output | 3 | Clock gear code (log2 of gear divide) |
| wdt_core | input | 1 | Watchdog output level from the watchdog logic |
| wdt_out | output | 1 | Watchdog pin level |
| ale_oe | output | 1 | Address-latch-enable output enable |
| sysclk_core | input | 1 | Clock-output level from the clock logic |
| clk_out | output | 1 | Clock output pin level |

## Verification
The qualifier is swept with low pulses of every length from 1 to 14 cycles. This separates the 9-cycle pulse, which must leave no trace, from the 10-cycle pulse, which must trigger a complete fetch. Each length uses a distinct vector, so the byte order and the address sequence are checked against values computed from that length. A second low pulse, placed inside a running fetch, tells an abort apart from a late start. Long held intervals are used to compare the forced register, gear and pin values with the pass-through values seen afterwards.

// File: rtl/cpu_boot_pkg.sv
package cpu_boot_pkg;
   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_FETCH = 3'd1,
      ST_DRAIN = 3'd2,
      ST_START = 3'd3,
      ST_RUN   = 3'd4
   } boot_state_e;
endpackage

// File: rtl/boot_pin_sync.sv
module boot_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_n,
   output logic sync_n
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("boot_pin_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) q <= 1'b0;
            else        q <= pin_n;
         end
         assign sync_n = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin_n};
         end
         assign sync_n = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/boot_low_qualifier.sv
module boot_low_qualifier #(
   parameter int LOW_CYCLES = 10
) (
   input  logic clk,
   input  logic por_n,
   input  logic sync_n,
   input  logic armed,
   output logic hit
);
   localparam int CW = (LOW_CYCLES < 2) ? 1 : $clog2(LOW_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(LOW_CYCLES - 1);

   generate
      if (LOW_CYCLES < 1) begin : g_bad_low
         $error("boot_low_qualifier: LOW_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                low_cnt <= '0;
      else if (sync_n || !armed) low_cnt <= '0;
      else if (low_cnt != LAST)  low_cnt <= low_cnt + 1'b1;
   end

   assign hit = armed && !sync_n && (low_cnt == LAST);

   // R1
   qual_low_run_chk: assert property (@(posedge clk) disable iff (!por_n)
      (hit && LOW_CYCLES > 1) |-> ($past(!sync_n) && $past(armed)));
endmodule

// File: rtl/boot_vector_loader.sv
module boot_vector_loader
   import cpu_boot_pkg::*;
#(
   parameter int              PC_W   = 24,
   parameter int              ADDR_W = 24,
   parameter logic [ADDR_W-1:0] VEC_BASE = 24'h008000
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sync_n,
   input  logic              hit,
   input  logic [7:0]        mem_rdata,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PC_W-1:0]   pc_value,
   output logic              cpu_start,
   output boot_state_e       state
);
   localparam int NB = PC_W / 8;
   localparam int IW = (NB < 2) ? 1 : $clog2(NB);
   localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

   generate
      if (PC_W % 8 != 0 || PC_W < 8) begin : g_bad_pc
         $error("boot_vector_loader: PC_W must be a positive multiple of 8");
      end
      if (ADDR_W < IW) begin : g_bad_addr
         $error("boot_vector_loader: ADDR_W too narrow");
      end
   endgenerate

   boot_state_e        st_q, st_d;
   logic [IW-1:0]      idx_q, cap_idx_q;
   logic               rd_pend_q;
   logic [NB-1:0][7:0] bytes_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_HOLD:  if (sync_n) st_d = ST_FETCH;
         ST_FETCH: if (!sync_n) st_d = ST_HOLD;
                   else if (idx_q == LAST_IDX) st_d = ST_DRAIN;
         ST_DRAIN: st_d = sync_n ? ST_START : ST_HOLD;
         ST_START: st_d = ST_RUN;
         ST_RUN:   if (hit) st_d = ST_HOLD;
         default:  st_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         st_q      <= ST_HOLD;
         idx_q     <= '0;
         cap_idx_q <= '0;
         rd_pend_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         rd_pend_q <= mem_rd;
         cap_idx_q <= idx_q;
         if (st_q == ST_FETCH && st_d == ST_FETCH) idx_q <= idx_q + 1'b1;
         else if (st_d != ST_FETCH)                idx_q <= '0;
      end
   end

   generate
      for (genvar b = 0; b < NB; b++) begin : g_byte
         always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
               bytes_q[b] <= '0;
            else if (rd_pend_q && cap_idx_q == IW'(b))
               bytes_q[b] <= mem_rdata;
         end
      end
   endgenerate

   assign mem_rd    = (st_q == ST_FETCH) && sync_n;
   assign mem_addr  = VEC_BASE + ADDR_W'(idx_q);
   assign pc_value  = bytes_q;
   assign cpu_start = (st_q == ST_START);
   assign state     = st_q;

   // R2
   fetch_first_addr_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mem_rd && !$past(mem_rd)) |-> (mem_addr == VEC_BASE));
   // R2
   fetch_step_addr_chk: assert property (@(posedge clk) disable iff (!por_n)
      (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + 1'b1));
   // R3
   start_single_chk: assert property (@(posedge clk) disable iff (!por_n)
      cpu_start |=> !cpu_start);
   // R3
   start_after_read_chk: assert property (@(posedge clk) disable iff (!por_n)
      cpu_start |-> ($past(rd_pend_q) && !mem_rd));
   // R7
   fetch_abort_chk: assert property (@(posedge clk) disable iff (!por_n)
      ((st_q == ST_FETCH || st_q == ST_DRAIN) && !sync_n) |=> (st_q == ST_HOLD && !cpu_start));
endmodule

// File: rtl/cpu_boot_sequencer.sv
module cpu_boot_sequencer
   import cpu_boot_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter int                LOW_CYCLES  = 10,
   parameter int                PC_W        = 24,
   parameter int                ADDR_W      = 24,
   parameter logic [ADDR_W-1:0] VEC_BASE    = 24'h008000,
   parameter logic [PC_W-1:0]   XSP_INIT    = 24'h000100,
   parameter logic [2:0]        IMASK_INIT  = 3'b111,
   parameter logic [2:0]        GEAR_INIT   = 3'd4
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_pin_n,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic [PC_W-1:0]   pc_value,
   output logic              cpu_start,
   output logic              cpu_hold,
   output logic              reset_active,
   output logic              init_en,
   output logic [2:0]        init_imask,
   output logic              init_max,
   output logic [2:0]        init_bank,
   output logic [PC_W-1:0]   init_xsp,
   output logic [2:0]        gear_sel,
   input  logic              wdt_core,
   output logic              wdt_out,
   output logic              ale_oe,
   input  logic              sysclk_core,
   output logic              clk_out
);
   logic        sync_n;
   logic        hit;
   boot_state_e state;

   boot_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .por_n(por_n), .pin_n(rst_pin_n), .sync_n(sync_n));

   boot_low_qualifier #(.LOW_CYCLES(LOW_CYCLES)) u_qual (
      .clk(clk), .por_n(por_n), .sync_n(sync_n),
      .armed(state == ST_RUN), .hit(hit));

   boot_vector_loader #(.PC_W(PC_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_load (
      .clk(clk), .por_n(por_n), .sync_n(sync_n), .hit(hit),
      .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
      .pc_value(pc_value), .cpu_start(cpu_start), .state(state));

   assign reset_active = (state == ST_HOLD);
   assign cpu_hold     = (state != ST_RUN);
   assign init_en      = reset_active;
   assign init_imask   = reset_active ? IMASK_INIT : 3'b000;
   assign init_max     = reset_active;
   assign init_bank    = 3'b000;
   assign init_xsp     = reset_active ? XSP_INIT : '0;
   assign gear_sel     = reset_active ? GEAR_INIT : 3'b000;
   assign wdt_out      = reset_active ? 1'b0 : wdt_core;
   assign ale_oe       = !reset_active;
   assign clk_out      = reset_active ? 1'b1 : sysclk_core;

   // R6
   held_pins_chk: assert property (@(posedge clk) disable iff (!por_n)
      reset_active |-> (!wdt_out && !ale_oe && clk_out));
   // R4
   held_no_read_chk: assert property (@(posedge clk) disable iff (!por_n)
      reset_active |-> (!mem_rd && !cpu_start && cpu_hold));
   // R8
   run_after_start_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!cpu_hold && $past(cpu_hold)) |-> $past(cpu_start));
endmodule

// File: tb/cpu_boot_sequencer_test.sv
module cpu_boot_sequencer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_pin_n = 1'b1;
   logic        mem_rd;
   logic [23:0] mem_addr;
   logic [7:0]  mem_rdata = 8'h00;
   logic [23:0] pc_value;
   logic        cpu_start, cpu_hold, reset_active, init_en, init_max;
   logic [2:0]  init_imask, init_bank, gear_sel;
   logic [23:0] init_xsp;
   logic        wdt_core = 1'b1, wdt_out, ale_oe, sysclk_core = 1'b0, clk_out;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [7:0] vec [3];
   int seen_hold, starts, nrd;
   logic [23:0] last_pc;
   logic [23:0] rd_log [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_boot_sequencer uut (
      .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .pc_value(pc_value), .cpu_start(cpu_start), .cpu_hold(cpu_hold),
      .reset_active(reset_active), .init_en(init_en), .init_imask(init_imask),
      .init_max(init_max), .init_bank(init_bank), .init_xsp(init_xsp),
      .gear_sel(gear_sel), .wdt_core(wdt_core), .wdt_out(wdt_out),
      .ale_oe(ale_oe), .sysclk_core(sysclk_core), .clk_out(clk_out));

   // byte memory with one cycle of read latency
   always @(posedge clk) begin
      if (mem_rd) begin
         if (mem_addr >= 24'h008000 && mem_addr <= 24'h008002)
            mem_rdata <= vec[mem_addr - 24'h008000];
         else
            mem_rdata <= 8'hEE;
      end
   end

   // observer, sampled away from the active edge
   always @(negedge clk) begin
      if (reset_active) seen_hold++;
      if (cpu_start) begin starts++; last_pc = pc_value; end
      if (mem_rd) begin
         if (nrd < 8) rd_log[nrd] = mem_addr;
         nrd++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_obs();
      seen_hold = 0; starts = 0; nrd = 0;
   endtask

   task automatic set_vec(input int seed);
      vec[0] = 8'(seed * 37 + 1);
      vec[1] = 8'(seed * 91 + 5);
      vec[2] = 8'(seed * 13 + 200);
   endtask

   function automatic logic [23:0] exp_pc();
      return {vec[2], vec[1], vec[0]};
   endfunction

   task automatic low_pulse(input int len);
      @(negedge clk) rst_pin_n = 1'b0;
      repeat (len) @(posedge clk);
      @(negedge clk) rst_pin_n = 1'b1;
   endtask

   initial begin
      clear_obs();
      set_vec(99);
      // R8 power-on state
      repeat (3) @(negedge clk);
      chk(reset_active && cpu_hold && !cpu_start, "R8 por held", {reset_active, cpu_hold, cpu_start}, 3'b110);
      chk(!wdt_out && !ale_oe && clk_out, "R6 por pins", {wdt_out, ale_oe, clk_out}, 3'b001);
      @(negedge clk) por_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(starts == 1, "R3 boot start count", starts, 1);
      chk(last_pc == exp_pc(), "R3 boot pc", last_pc, exp_pc());
      chk(!cpu_hold, "R8 running after start", cpu_hold, 0);
      chk(pc_value == exp_pc(), "R3 pc held", pc_value, exp_pc());

      // R1 R2 R3 sweep of low pulse lengths
      for (int len = 1; len <= 14; len++) begin
         set_vec(len);
         clear_obs();
         low_pulse(len);
         repeat (25) @(negedge clk);
         if (len >= 10) begin
            chk(seen_hold > 0, "R1 accepted long pulse", len, 10);
            chk(nrd == 3, "R2 read count", nrd, 3);
            for (int k = 0; k < 3; k++)
               chk(rd_log[k] == 24'h008000 + 24'(k), "R2 read address", rd_log[k], 24'h008000 + 24'(k));
            chk(starts == 1, "R3 start count", starts, 1);
            chk(last_pc == exp_pc(), "R3 assembled pc", last_pc, exp_pc());
         end else begin
            chk(seen_hold == 0, "R1 short pulse ignored", seen_hold, 0);
            chk(nrd == 0 && starts == 0, "R1 no fetch on short pulse", nrd + starts, 0);
         end
         chk(!cpu_hold, "R8 running after pulse", cpu_hold, 0);
      end

      // R4 R5 R6 held values against pass-through
      wdt_core = 1'b1; sysclk_core = 1'b0;
      @(negedge clk) rst_pin_n = 1'b0;
      repeat (20) @(negedge clk);
      chk(reset_active && init_en, "R4 held init_en", {reset_active, init_en}, 2'b11);
      chk(init_imask == 3'b111 && init_max && init_bank == 3'b000, "R4 status init",
          {init_imask, init_max, init_bank}, {3'b111, 1'b1, 3'b000});
      chk(init_xsp == 24'h000100, "R4 stack init", init_xsp, 24'h000100);
      chk(gear_sel == 3'd4, "R5 gear init", gear_sel, 3'd4);
      chk(!wdt_out && !ale_oe && clk_out, "R6 held pins", {wdt_out, ale_oe, clk_out}, 3'b001);
      chk(!mem_rd && cpu_hold, "R8 held no read", {mem_rd, cpu_hold}, 2'b01);
      set_vec(200);
      clear_obs();
      rst_pin_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(!init_en && init_xsp == 0 && gear_sel == 0 && init_imask == 0,
          "R4 R5 released init", {init_en, gear_sel, init_imask}, 0);
      chk(wdt_out == 1'b1 && ale_oe && clk_out == 1'b0, "R6 pass-through", {wdt_out, ale_oe, clk_out}, 3'b110);
      wdt_core = 1'b0; sysclk_core = 1'b1;
      @(negedge clk);
      chk(wdt_out == 1'b0 && clk_out == 1'b1, "R6 pass-through toggled", {wdt_out, clk_out}, 2'b01);
      chk(last_pc == exp_pc() && starts == 1, "R3 pc after long hold", last_pc, exp_pc());

      // R7 abort during fetch
      @(negedge clk) rst_pin_n = 1'b0;
      repeat (15) @(negedge clk);
      set_vec(7);
      clear_obs();
      rst_pin_n = 1'b1;
      while (nrd == 0) @(negedge clk);
      set_vec(8);
      rst_pin_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(reset_active && starts == 0, "R7 abort held no start", {reset_active, 4'(starts)}, 5'b10000);
      rst_pin_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(starts == 1, "R7 single start after abort", starts, 1);
      chk(last_pc == exp_pc(), "R7 refetched pc", last_pc, exp_pc());
      chk(nrd >= 4 && rd_log[nrd-3] == 24'h008000, "R7 refetch from base", rd_log[nrd-3], 24'h008000);

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule